// File: doc/BRIEF.md
# Weight-Stationary Systolic Matrix Multiplier

This block multiplies a stream of signed 8-bit activation vectors by an N x N signed 8-bit weight matrix held inside a square grid of multiply-accumulate cells. Every cell keeps one weight. Activations move one cell to the right per clock, and partial sums move one cell down per clock. The bottom edge of the grid gives one dot product per column. The caller presents one plain, unskewed vector per cycle. Per-row delay stages at the input stagger the vector elements, and per-column delay stages at the output line them up again, so each result row leaves as one word with one valid pulse.

Weights enter through the same left-edge path as activations. A vector presented with the load flag set carries one column of the weight matrix. The load flag and a column tag travel through the grid with the data, and only the cell whose column matches the tag stores the value. After loading, the weights stay in the cells for any number of compute vectors. Because loads and computes travel through the grid in order, a new weight set takes effect from exactly the first compute vector presented after it, while vectors already in the grid finish with the old weights.

A compute vector can be marked as the end of a batch. The matching result row is then flagged with a done pulse.

Top module: `sysarr_top`

## Requirements
- R1: While reset is asserted and in the first cycles after its release, `res_valid_o`, `done_o` and `res_o` are zero. All weights reset to zero, so a compute vector presented before any load gives an all-zero result row.
- R2: Consecutive load vectors (`vec_valid_i` and `vec_load_i` high) are numbered k = 0, 1, ..., wrapping after N-1. Load vector k writes its element i (bits `[i*8 +: 8]`) into the weight at row i, column k. Any compute vector resets the numbering to 0.
- R3: For a compute vector a, result column j (bits `[j*32 +: 32]` of `res_o`) equals the signed sum over i of a[i] * W[i][j]. It is exact for every pair of 8-bit operands, including -128 * -128, for N up to 16.
- R4: The result row of a compute vector presented in cycle t appears, with `res_valid_o` high for exactly one cycle, in cycle t + 2N - 1. All columns appear in that same cycle.
- R5: Compute vectors may be presented on every cycle, and results then leave on every cycle. For a batch of N back-to-back vectors, the last result appears 3N - 2 cycles after the first vector is presented.
- R6: Loaded weights remain in place across any number of compute vectors until another load writes them.
- R7: Load vectors produce no result row. A compute vector presented before a load uses the old weights, and one presented after it uses the new weights, even with no idle cycle in between.
- R8: `done_o` is high only together with `res_valid_o`, and only on the row of a compute vector presented with `vec_last_i` high. `vec_last_i` has no effect on load vectors.
- R9: When `vec_valid_i` is low, `vec_i`, `vec_load_i` and `vec_last_i` are ignored. No result appears, and neither weights nor later results change.
- R10: A partial load of fewer than N vectors, followed by a compute vector, rewrites only the first columns in order. The other columns keep their earlier weights.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vec_valid_i | input | 1 | A vector is presented this cycle |
| vec_load_i | input | 1 | The vector is one weight column rather than activations |
| vec_last_i | input | 1 | The compute vector closes a batch |
| vec_i | input | N*8 | Vector elements; element i at bits [i*8 +: 8], signed |
| res_valid_o | output | 1 | A result row is present |
| res_o | output | N*32 | Result row; column j at bits [j*32 +: 32], signed |
| done_o | output | 1 | The result row belongs to the last vector of a batch |

## Verification
The assertions check three things on every cycle. A done pulse never appears without a result row. Every result row is matched by an earlier compute vector that has not yet produced its row, and the number of such vectors in the grid never exceeds the pipeline depth. Every result column stays within the range that N products of 8-bit values can reach.

Only the bench scenarios can show that the numbers are right. These scenarios cover the column-to-weight mapping of the load sequence, exact arithmetic across a corner-value sweep of all activation combinations, the exact output cycle, and the switch-over point when loads and computes are packed back to back. They also show that partial loads leave the other columns alone and that idle cycles with garbage on the inputs change nothing.

// File: rtl/sa_pkg.sv
`timescale 1ns/1ps
package sa_pkg;

  // Width of an index that selects one of n columns (at least one bit).
  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // Minimum accumulator width for n products of two aw-bit signed values.
  function automatic int acc_w_min(input int aw, input int n);
    return 2 * aw + idx_w(n) + 1;
  endfunction

  // Fixed latency from a presented vector to its aligned result row.
  function automatic int row_latency(input int n);
    return 2 * n - 1;
  endfunction

endpackage

// File: rtl/sa_delay.sv
`timescale 1ns/1ps
// Plain register chain of parameterised depth; depth 0 is a wire.
module sa_delay #(
  parameter int W = 8,
  parameter int D = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] d_o
);

  generate
    if (D == 0) begin : g_wire
      logic clk_unused;
      assign clk_unused = clk ^ rst_n;
      assign d_o = d_i;
    end else begin : g_chain
      logic [W-1:0] stage_q [D];
      logic [W-1:0] stage_n [D];

      always_comb begin
        stage_n[0] = d_i;
        for (int s = 1; s < D; s++) begin
          stage_n[s] = stage_q[s-1];
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int s = 0; s < D; s++) begin
            stage_q[s] <= '0;
          end
        end else begin
          for (int s = 0; s < D; s++) begin
            stage_q[s] <= stage_n[s];
          end
        end
      end

      assign d_o = stage_q[D-1];
    end
  endgenerate

endmodule

// File: rtl/sa_cell.sv
`timescale 1ns/1ps
// One grid cell: holds a weight, forwards the activation item east,
// forwards the running sum south.
module sa_cell #(
  parameter int AW  = 8,
  parameter int SW  = 32,
  parameter int TW  = 2,
  parameter int COL = 0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic signed [AW-1:0] a_i,
  input  logic                 ld_i,
  input  logic [TW-1:0]        tag_i,
  input  logic signed [SW-1:0] ps_i,
  output logic signed [AW-1:0] a_o,
  output logic                 ld_o,
  output logic [TW-1:0]        tag_o,
  output logic signed [SW-1:0] ps_o
);

  localparam int PW = 2 * AW;

  logic signed [AW-1:0] a_q, w_q, w_n;
  logic                 ld_q;
  logic [TW-1:0]        tag_q;
  logic signed [SW-1:0] ps_q, ps_n;
  logic signed [PW-1:0] prod;
  logic                 w_en;

  // Next-state logic
  always_comb begin
    w_en = ld_i && (tag_i == TW'(COL));
    w_n  = a_i;
    prod = a_i * w_q;
    if (ld_i) begin
      ps_n = ps_i;
    end else begin
      ps_n = ps_i + {{(SW-PW){prod[PW-1]}}, prod};
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q   <= '0;
      ld_q  <= 1'b0;
      tag_q <= '0;
      ps_q  <= '0;
      w_q   <= '0;
    end else begin
      a_q   <= a_i;
      ld_q  <= ld_i;
      tag_q <= tag_i;
      ps_q  <= ps_n;
      if (w_en) begin
        w_q <= w_n;
      end
    end
  end

  assign a_o   = a_q;
  assign ld_o  = ld_q;
  assign tag_o = tag_q;
  assign ps_o  = ps_q;

endmodule

// File: rtl/sysarr_top.sv
`timescale 1ns/1ps
module sysarr_top #(
  parameter int N  = 4,
  parameter int AW = 8,
  parameter int SW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            vec_valid_i,
  input  logic            vec_load_i,
  input  logic            vec_last_i,
  input  logic [N*AW-1:0] vec_i,
  output logic            res_valid_o,
  output logic [N*SW-1:0] res_o,
  output logic            done_o
);

  localparam int TW  = sa_pkg::idx_w(N);
  localparam int IW  = AW + 1 + TW;          // {act, load flag, column tag}
  localparam int LAT = sa_pkg::row_latency(N);

  // ---------------------------------------------------------------
  // Load column counter
  // ---------------------------------------------------------------
  logic [TW-1:0] ld_col_q, ld_col_n;
  logic          ld_col_en;

  always_comb begin
    ld_col_en = vec_valid_i;
    if (!vec_load_i) begin
      ld_col_n = '0;
    end else if (ld_col_q == TW'(N-1)) begin
      ld_col_n = '0;
    end else begin
      ld_col_n = ld_col_q + TW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_col_q <= '0;
    end else if (ld_col_en) begin
      ld_col_q <= ld_col_n;
    end
  end

  // ---------------------------------------------------------------
  // Input items and per-row skew (row r delayed by r cycles)
  // ---------------------------------------------------------------
  logic [IW-1:0] item_in [N];
  logic [IW-1:0] item_sk [N];

  always_comb begin
    for (int r = 0; r < N; r++) begin
      if (vec_valid_i) begin
        item_in[r] = {vec_i[r*AW +: AW], vec_load_i,
                      (vec_load_i ? ld_col_q : TW'(0))};
      end else begin
        item_in[r] = '0;
      end
    end
  end

  generate
    for (genvar r = 0; r < N; r++) begin : g_skew
      sa_delay #(.W(IW), .D(r)) u_skew (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (item_in[r]),
        .d_o   (item_sk[r])
      );
    end
  endgenerate

  // ---------------------------------------------------------------
  // Cell grid
  // ---------------------------------------------------------------
  logic signed [AW-1:0] act  [N][N];
  logic                 ldf  [N][N];
  logic [TW-1:0]        tagf [N][N];
  logic signed [SW-1:0] ps   [N][N];

  generate
    for (genvar r = 0; r < N; r++) begin : g_row
      for (genvar c = 0; c < N; c++) begin : g_col
        logic signed [AW-1:0] a_w;
        logic                 ld_w;
        logic [TW-1:0]        tag_w;
        logic signed [SW-1:0] ps_w;

        if (c == 0) begin : g_west_edge
          assign a_w   = item_sk[r][IW-1 -: AW];
          assign ld_w  = item_sk[r][TW];
          assign tag_w = item_sk[r][TW-1:0];
        end else begin : g_west_cell
          assign a_w   = act[r][c-1];
          assign ld_w  = ldf[r][c-1];
          assign tag_w = tagf[r][c-1];
        end

        if (r == 0) begin : g_top_edge
          assign ps_w = '0;
        end else begin : g_top_cell
          assign ps_w = ps[r-1][c];
        end

        sa_cell #(.AW(AW), .SW(SW), .TW(TW), .COL(c)) u_cell (
          .clk   (clk),
          .rst_n (rst_n),
          .a_i   (a_w),
          .ld_i  (ld_w),
          .tag_i (tag_w),
          .ps_i  (ps_w),
          .a_o   (act[r][c]),
          .ld_o  (ldf[r][c]),
          .tag_o (tagf[r][c]),
          .ps_o  (ps[r][c])
        );
      end

      // Items leaving the east edge are dropped.
      logic [IW-1:0] east_unused;
      assign east_unused = {act[r][N-1], ldf[r][N-1], tagf[r][N-1]};
    end
  endgenerate

  // ---------------------------------------------------------------
  // Output de-skew (column c delayed by N-1-c cycles)
  // ---------------------------------------------------------------
  generate
    for (genvar c = 0; c < N; c++) begin : g_deskew
      sa_delay #(.W(SW), .D(N-1-c)) u_deskew (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (ps[N-1][c]),
        .d_o   (res_o[c*SW +: SW])
      );
    end
  endgenerate

  // ---------------------------------------------------------------
  // Row valid and batch-end flags
  // ---------------------------------------------------------------
  logic [1:0] flag_in, flag_out;

  assign flag_in = {vec_valid_i && !vec_load_i,
                    vec_valid_i && !vec_load_i && vec_last_i};

  sa_delay #(.W(2), .D(LAT)) u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (flag_in),
    .d_o   (flag_out)
  );

  assign res_valid_o = flag_out[1];
  assign done_o      = flag_out[0];

endmodule

// File: rtl/sa_checker.sv
`timescale 1ns/1ps
module sa_checker #(
  parameter int N  = 4,
  parameter int AW = 8,
  parameter int SW = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            vec_valid_i,
  input logic            vec_load_i,
  input logic            res_valid_o,
  input logic [N*SW-1:0] res_o,
  input logic            done_o
);

  localparam int     LAT   = 2 * N - 1;
  localparam int     CW    = $clog2(2 * N + 1) + 1;
  localparam longint BOUND = longint'(N) << (2 * AW - 2);

  // Compute vectors accepted and not yet answered.
  logic [CW-1:0] pend_q, pend_n;

  always_comb begin
    pend_n = pend_q + CW'(vec_valid_i && !vec_load_i) - CW'(res_valid_o);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else begin
      pend_q <= pend_n;
    end
  end

  assert_done_with_row_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> res_valid_o);

  // R7: load vectors and idle cycles never produce a row
  assert_row_owed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid_o |-> (pend_q != '0));

  assert_inflight_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q <= CW'(LAT));

  generate
    for (genvar c = 0; c < N; c++) begin : g_col
      logic signed [SW-1:0] col;
      assign col = res_o[c*SW +: SW];
      assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o |-> (($signed(col) <= BOUND) && ($signed(col) >= -BOUND)));
    end
  endgenerate

endmodule

bind sysarr_top sa_checker #(.N(N), .AW(AW), .SW(SW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .vec_valid_i (vec_valid_i),
  .vec_load_i  (vec_load_i),
  .res_valid_o (res_valid_o),
  .res_o       (res_o),
  .done_o      (done_o)
);

// File: tb/sim_sysarr_top.sv
`timescale 1ns/1ps
module sim_sysarr_top;

  localparam int N   = 4;
  localparam int AW  = 8;
  localparam int SW  = 32;
  localparam int LAT = 2 * N - 1;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            vec_valid_i, vec_load_i, vec_last_i;
  logic [N*AW-1:0] vec_i;
  logic            res_valid_o, done_o;
  logic [N*SW-1:0] res_o;

  always #4 clk = ~clk;   // 125 MHz

  sysarr_top #(.N(N), .AW(AW), .SW(SW)) u0 (
    .clk(clk), .rst_n(rst_n), .vec_valid_i(vec_valid_i), .vec_load_i(vec_load_i),
    .vec_last_i(vec_last_i), .vec_i(vec_i), .res_valid_o(res_valid_o),
    .res_o(res_o), .done_o(done_o)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int W  [N][N];       // bench model of resident weights
  int nw [N][N];       // weight set to be loaded next
  int ldcol = 0;
  logic [N*SW-1:0] exp_row  [int];
  bit              exp_last [int];
  string           exp_req  [int];
  int n_vec = 0, n_bad = 0;
  bit mon_en = 0, finished = 0;
  int last_done_cyc = -1;
  int last_push_cyc = 0;
  int unsigned seed = 32'h1badf00d;

  task automatic fail(input string req, input string what,
                      input logic [N*SW-1:0] got, input logic [N*SW-1:0] exp);
    n_bad++;
    $display("FAIL %s %s at cycle %0d: actual %h expected %h", req, what, cyc, got, exp);
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [N*SW-1:0] got, input logic [N*SW-1:0] exp);
    n_vec++;
    if (!ok) fail(req, what, got, exp);
  endtask

  function automatic int rnd8();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return int'($signed(seed[7:0]));
  endfunction

  function automatic logic [N*AW-1:0] pk(input int a[N]);
    logic [N*AW-1:0] v;
    for (int i = 0; i < N; i++) v[i*AW +: AW] = AW'(a[i]);
    return v;
  endfunction

  task automatic push(input bit v, input bit ld, input bit last,
                      input logic [N*AW-1:0] d, input string req);
    @(negedge clk);
    vec_valid_i = v; vec_load_i = ld; vec_last_i = last; vec_i = d;
    last_push_cyc = cyc;
    if (v && ld) begin
      for (int i = 0; i < N; i++) W[i][ldcol] = int'($signed(d[i*AW +: AW]));
      ldcol = (ldcol == N - 1) ? 0 : ldcol + 1;
    end else if (v) begin
      logic [N*SW-1:0] row;
      ldcol = 0;
      for (int j = 0; j < N; j++) begin
        longint s = 0;
        for (int i = 0; i < N; i++) s += longint'(int'($signed(d[i*AW +: AW]))) * W[i][j];
        row[j*SW +: SW] = SW'(s);
      end
      exp_row[cyc + LAT]  = row;
      exp_last[cyc + LAT] = last;
      exp_req[cyc + LAT]  = req;
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      int g[N];
      for (int i = 0; i < N; i++) g[i] = rnd8();
      push(1'b0, rnd8()[0], rnd8()[0], pk(g), "R9");
    end
  endtask

  task automatic load_nw(input int cols, input string req);
    for (int k = 0; k < cols; k++) begin
      int col[N];
      for (int i = 0; i < N; i++) col[i] = nw[i][k];
      push(1'b1, 1'b1, 1'b0, pk(col), req);
    end
  endtask

  // Output monitor, sampled away from the rising edge
  always @(negedge clk) begin
    if (mon_en) begin
      bit ev;
      ev = exp_row.exists(cyc);
      n_vec++;
      if (res_valid_o !== ev) begin
        fail(ev ? exp_req[cyc] : "R7", "res_valid_o", {{(N*SW-1){1'b0}}, res_valid_o},
             {{(N*SW-1){1'b0}}, ev});
      end else if (ev) begin
        n_vec++;
        if (res_o !== exp_row[cyc]) fail(exp_req[cyc], "result row", res_o, exp_row[cyc]);
        n_vec++;
        if (done_o !== exp_last[cyc])
          fail("R8", "done_o", {{(N*SW-1){1'b0}}, done_o}, {{(N*SW-1){1'b0}}, exp_last[cyc]});
      end else if (done_o !== 1'b0) begin
        fail("R8", "done_o without row", {{(N*SW-1){1'b0}}, done_o}, '0);
      end
      if (done_o && ev) last_done_cyc = cyc;
      if (ev) begin
        exp_row.delete(cyc); exp_last.delete(cyc); exp_req.delete(cyc);
      end
    end
  end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL R5 watchdog expired: actual hung expected drained");
      summary();
      $finish;
    end
  end

  initial begin
    int vals[6] = '{-128, -127, -1, 0, 1, 127};
    int total;
    int c0;
    rst_n = 1'b0; vec_valid_i = 0; vec_load_i = 0; vec_last_i = 0; vec_i = '0;
    for (int i = 0; i < N; i++) for (int j = 0; j < N; j++) W[i][j] = 0;
    repeat (3) @(negedge clk);
    // R1: outputs held at zero in reset
    chk(res_valid_o === 1'b0 && done_o === 1'b0, "R1", "flags in reset",
        {res_valid_o, done_o}, '0);
    chk(res_o === '0, "R1", "row in reset", res_o, '0);
    @(negedge clk);
    rst_n = 1'b1;
    mon_en = 1'b1;
    @(negedge clk);
    chk(res_valid_o === 1'b0 && res_o === '0, "R1", "after release", res_o, '0);

    // R1: zero weights after reset give a zero row
    begin int a[N]; for (int i = 0; i < N; i++) a[i] = 17 * (i + 1) - 60;
      push(1, 0, 0, pk(a), "R1"); end
    idle(LAT + 1);

    // R2: distinct weights, read back rows with unit vectors
    for (int i = 0; i < N; i++) for (int j = 0; j < N; j++)
      nw[i][j] = (i * N + j + 1) * (((i + j) % 2) ? -1 : 1);
    load_nw(N, "R2");
    for (int i = 0; i < N; i++) begin
      int a[N];
      for (int k = 0; k < N; k++) a[k] = (k == i) ? 1 : 0;
      push(1, 0, 0, pk(a), "R2");
      for (int k = 0; k < N; k++) a[k] = (k == i) ? -1 : 0;
      push(1, 0, 0, pk(a), "R2");
    end
    idle(LAT + 1);

    // R3: full corner sweep of activations against mixed weights
    for (int i = 0; i < N; i++) for (int j = 0; j < N; j++)
      nw[i][j] = ((i + j) % 3 == 0) ? -128 : ((i + j) % 3 == 1) ? 127 : rnd8();
    load_nw(N, "R2");
    total = 1;
    for (int i = 0; i < N; i++) total *= 6;
    for (int idx = 0; idx < total; idx++) begin
      int a[N]; int t = idx;
      for (int i = 0; i < N; i++) begin a[i] = vals[t % 6]; t /= 6; end
      push(1, 0, 0, pk(a), "R3");
    end

    // R6: one load, then a long stream; extreme weights reach the largest sum
    for (int i = 0; i < N; i++) for (int j = 0; j < N; j++) nw[i][j] = -128;
    load_nw(N, "R6");
    for (int idx = 0; idx < total; idx++) begin
      int a[N]; int t = idx;
      for (int i = 0; i < N; i++) begin a[i] = vals[t % 6]; t /= 6; end
      push(1, 0, 0, pk(a), "R6");
    end
    idle(LAT + 1);

    // R5: batch of N back-to-back vectors, last one marked
    for (int b = 0; b < N; b++) begin
      int a[N];
      for (int i = 0; i < N; i++) a[i] = rnd8();
      push(1, 0, (b == N - 1), pk(a), "R5");
      if (b == 0) c0 = last_push_cyc;
    end
    idle(LAT + 2);
    chk(last_done_cyc == c0 + 3 * N - 2, "R5", "batch completion cycle",
        (N*SW)'(last_done_cyc), (N*SW)'(c0 + 3 * N - 2));

    // R7 / R8: computes, loads (with last set, ignored), computes, no gaps
    for (int k = 0; k < 3; k++) begin
      int a[N]; for (int i = 0; i < N; i++) a[i] = rnd8();
      push(1, 0, 0, pk(a), "R7");
    end
    for (int k = 0; k < N; k++) begin
      int col[N]; for (int i = 0; i < N; i++) begin col[i] = rnd8(); end
      push(1, 1, 1, pk(col), "R8");
    end
    for (int k = 0; k < 3; k++) begin
      int a[N]; for (int i = 0; i < N; i++) a[i] = rnd8();
      push(1, 0, (k == 1), pk(a), "R7");
    end

    // R9: idle cycles with garbage between computes
    for (int k = 0; k < 20; k++) begin
      int a[N]; for (int i = 0; i < N; i++) a[i] = rnd8();
      push(1, 0, 0, pk(a), "R9");
      idle(1 + (k % 3));
    end

    // R10: partial loads rewrite leading columns only
    for (int i = 0; i < N; i++) for (int j = 0; j < N; j++) nw[i][j] = rnd8();
    load_nw(2, "R10");
    for (int k = 0; k < 4; k++) begin
      int a[N]; for (int i = 0; i < N; i++) a[i] = rnd8();
      push(1, 0, 0, pk(a), "R10");
    end
    for (int i = 0; i < N; i++) for (int j = 0; j < N; j++) nw[i][j] = rnd8();
    load_nw(1, "R10");
    for (int k = 0; k < 4; k++) begin
      int a[N]; for (int i = 0; i < N; i++) a[i] = rnd8();
      push(1, 0, 0, pk(a), "R10");
    end
    idle(LAT + 2);

    chk(exp_row.size() == 0, "R4", "rows left unanswered",
        (N*SW)'(exp_row.size()), '0);
    finished = 1'b1;
    summary();
    $finish;
  end

endmodule